// File: doc/BRIEF.md
# Barrel Thread Issue Sequencer

This block chooses which hardware thread issues and which program counter it uses. It is meant for a processor that switches threads on every cycle. A counter steps through the threads in a fixed ring, one thread per clock. Each cycle it presents a thread number and that thread's banked program counter to the fetch stage. The number of threads equals the number of pipeline stages. Because of this, a thread's next fetch can only happen after its previous instruction has left the pipeline, and no stall or bypass logic is needed.

A tag holding the issue-valid bit and the thread number moves down a shift register, one stage per clock. The tail of that register shows the writeback stage which thread's instruction has arrived there. Writeback returns the next program counter along with a thread number, and only that thread's bank entry is updated. An enable bit per thread turns a disabled thread's slot into a bubble, and the ring timing does not change. A tag comparator watches for the thread being issued also appearing in a later stage.

Top module: `barrel_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the ring returns to thread 0 and every tag stage is emptied. Each thread t reloads its program counter with `RST_BASE + t*RST_STRIDE`, where the defaults are 0x1000 and 0x100.
- R2: `fetch_tid` advances by one on every clock after reset and wraps from `N_THREADS-1` to 0. Neither the enables nor writeback affect this sequence.
- R3: `fetch_pc` always equals the banked program counter of the thread shown on `fetch_tid`.
- R4: `wb_slot_valid` and `wb_slot_tid` show the issue-valid bit and thread number that were issued exactly `N_THREADS-1` cycles earlier. With the ring order this means the thread number is `fetch_tid+1` modulo `N_THREADS`.
- R5: A clock edge with `wb_valid` high loads `wb_pc` into the bank entry of thread `wb_tid`. The entries of all other threads stay unchanged.
- R6: A writeback aimed at the thread that is issuing in the same cycle does not change that cycle's `fetch_pc`. The new value first appears when that thread next issues, `N_THREADS` cycles later.
- R7: While bit t of `thread_en` is low, thread t's slot presents `fetch_valid` low and sends a tag with its valid bit clear down the pipe. The ring timing stays unchanged.
- R8: `issue_hazard` goes high when a valid issue's thread number matches a valid tag in any later stage. Under the one-thread-per-stage ring this never happens.
- R9: A writeback whose `wb_tid` is `N_THREADS` or larger changes no bank entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thread_en | input | N_THREADS | Per-thread issue enable, bit t for thread t |
| wb_valid | input | 1 | Writeback of a next program counter |
| wb_tid | input | TID_W | Thread number of the writeback |
| wb_pc | input | PC_W | Next program counter to store |
| fetch_valid | output | 1 | The current slot issues a real instruction |
| fetch_tid | output | TID_W | Thread number issuing this cycle |
| fetch_pc | output | PC_W | Banked program counter of the issuing thread |
| wb_slot_valid | output | 1 | Valid bit of the tag at the writeback stage |
| wb_slot_tid | output | TID_W | Thread number of the tag at the writeback stage |
| issue_hazard | output | 1 | The issuing thread still has a tag in flight |

## Verification
Two things can happen in one cycle: a bank read for fetch and a bank write from writeback. In normal traffic the write goes to the thread that issues next. Feeding writeback from the tail tag therefore checks that an updated counter shows up exactly one cycle later. The bench also aims a writeback at the thread that is fetching in that same cycle. It checks that `fetch_pc` keeps its old value during that cycle, and then that the new value appears when the ring comes back to that thread.

// File: rtl/barrel_pkg.sv
package barrel_pkg;

    localparam int TAG_MAX_W = 8;

    typedef logic [TAG_MAX_W-1:0] tag_t;

    typedef struct packed {
        logic live;
        tag_t tid;
    } slot_t;

    function automatic tag_t tag_next(input tag_t cur, input int unsigned count);
        if (32'(cur) + 32'd1 >= count) begin
            return '0;
        end
        return cur + tag_t'(1);
    endfunction

    function automatic logic slot_hit(input slot_t s, input tag_t tid);
        return s.live && (s.tid == tid);
    endfunction

endpackage

// File: rtl/barrel_rotor.sv
module barrel_rotor
    import barrel_pkg::*;
#(
    parameter int N_THREADS = 7,
    parameter int TID_W     = 3
) (
    input  logic             clk,
    input  logic             rst,
    output logic [TID_W-1:0] cur_tid
);

    logic [TID_W-1:0] ring_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ring_q <= '0;
        end else begin
            ring_q <= TID_W'(tag_next(tag_t'(ring_q), N_THREADS));
        end
    end

    assign cur_tid = ring_q;

endmodule

// File: rtl/barrel_tag_pipe.sv
module barrel_tag_pipe
    import barrel_pkg::*;
#(
    parameter int N_THREADS = 7,
    parameter int TID_W     = 3,
    localparam int DEPTH    = N_THREADS - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_live,
    input  logic [TID_W-1:0] in_tid,
    output slot_t            stages [DEPTH]
);

    slot_t head;

    always_comb begin
        head.live = in_live;
        head.tid  = tag_t'(in_tid);
    end

    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        slot_t src;
        if (k == 0) begin : g_first
            assign src = head;
        end else begin : g_rest
            assign src = stages[k-1];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                stages[k] <= '0;
            end else begin
                stages[k] <= src;
            end
        end
    end

endmodule

// File: rtl/barrel_inflight.sv
module barrel_inflight
    import barrel_pkg::*;
#(
    parameter int N_THREADS = 7,
    parameter int TID_W     = 3,
    localparam int DEPTH    = N_THREADS - 1
) (
    input  slot_t            stages [DEPTH],
    input  logic             issue_live,
    input  logic [TID_W-1:0] issue_tid,
    output logic             conflict
);

    logic busy;

    always_comb begin
        busy = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            busy = busy | slot_hit(stages[k], tag_t'(issue_tid));
        end
    end

    assign conflict = issue_live & busy;

endmodule

// File: rtl/barrel_pc_bank.sv
module barrel_pc_bank #(
    parameter int N_THREADS              = 7,
    parameter int TID_W                  = 3,
    parameter int PC_W                   = 32,
    parameter logic [PC_W-1:0] RST_BASE   = 'h1000,
    parameter logic [PC_W-1:0] RST_STRIDE = 'h100
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [TID_W-1:0]          wr_tid,
    input  logic [PC_W-1:0]           wr_pc,
    input  logic [TID_W-1:0]          rd_tid,
    output logic [PC_W-1:0]           rd_pc,
    output logic [N_THREADS*PC_W-1:0] pc_flat
);

    logic [PC_W-1:0] pc_q [N_THREADS];

    for (genvar t = 0; t < N_THREADS; t++) begin : g_thread
        localparam logic [PC_W-1:0] BOOT = RST_BASE + PC_W'(t) * RST_STRIDE;

        always_ff @(posedge clk) begin
            if (rst) begin
                pc_q[t] <= BOOT;
            end else if (wr_en && (wr_tid == TID_W'(t))) begin
                pc_q[t] <= wr_pc;
            end
        end

        assign pc_flat[t*PC_W +: PC_W] = pc_q[t];
    end

    always_comb begin
        rd_pc = '0;
        for (int t = 0; t < N_THREADS; t++) begin
            if (rd_tid == TID_W'(t)) begin
                rd_pc = pc_q[t];
            end
        end
    end

endmodule

// File: rtl/barrel_sequencer.sv
module barrel_sequencer
    import barrel_pkg::*;
#(
    parameter int N_THREADS               = 7,
    parameter int PC_W                    = 32,
    parameter logic [PC_W-1:0] RST_BASE   = 'h1000,
    parameter logic [PC_W-1:0] RST_STRIDE = 'h100,
    localparam int TID_W = (N_THREADS > 1) ? $clog2(N_THREADS) : 1,
    localparam int DEPTH = N_THREADS - 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_THREADS-1:0] thread_en,
    input  logic                 wb_valid,
    input  logic [TID_W-1:0]     wb_tid,
    input  logic [PC_W-1:0]      wb_pc,
    output logic                 fetch_valid,
    output logic [TID_W-1:0]     fetch_tid,
    output logic [PC_W-1:0]      fetch_pc,
    output logic                 wb_slot_valid,
    output logic [TID_W-1:0]     wb_slot_tid,
    output logic                 issue_hazard
);

    logic [TID_W-1:0]          cur_tid;
    logic                      issue_live;
    slot_t                     stages [DEPTH];
    logic [N_THREADS*PC_W-1:0] pc_flat;

    barrel_rotor #(
        .N_THREADS (N_THREADS),
        .TID_W     (TID_W)
    ) u_rotor (
        .clk     (clk),
        .rst     (rst),
        .cur_tid (cur_tid)
    );

    always_comb begin
        issue_live = 1'b0;
        for (int t = 0; t < N_THREADS; t++) begin
            if (cur_tid == TID_W'(t)) begin
                issue_live = thread_en[t];
            end
        end
    end

    barrel_tag_pipe #(
        .N_THREADS (N_THREADS),
        .TID_W     (TID_W)
    ) u_pipe (
        .clk     (clk),
        .rst     (rst),
        .in_live (issue_live),
        .in_tid  (cur_tid),
        .stages  (stages)
    );

    barrel_inflight #(
        .N_THREADS (N_THREADS),
        .TID_W     (TID_W)
    ) u_inflight (
        .stages     (stages),
        .issue_live (issue_live),
        .issue_tid  (cur_tid),
        .conflict   (issue_hazard)
    );

    barrel_pc_bank #(
        .N_THREADS  (N_THREADS),
        .TID_W      (TID_W),
        .PC_W       (PC_W),
        .RST_BASE   (RST_BASE),
        .RST_STRIDE (RST_STRIDE)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wb_valid),
        .wr_tid  (wb_tid),
        .wr_pc   (wb_pc),
        .rd_tid  (cur_tid),
        .rd_pc   (fetch_pc),
        .pc_flat (pc_flat)
    );

    assign fetch_valid   = issue_live;
    assign fetch_tid     = cur_tid;
    assign wb_slot_valid = stages[DEPTH-1].live;
    assign wb_slot_tid   = stages[DEPTH-1].tid[TID_W-1:0];

endmodule

// File: rtl/barrel_sequencer_chk.sv
module barrel_sequencer_chk #(
    parameter int N_THREADS             = 7,
    parameter int PC_W                  = 32,
    parameter int TID_W                 = 3,
    parameter logic [PC_W-1:0] RST_BASE = 'h1000
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      wb_valid,
    input logic [TID_W-1:0]          wb_tid,
    input logic [PC_W-1:0]           wb_pc,
    input logic [TID_W-1:0]          fetch_tid,
    input logic                      wb_slot_valid,
    input logic [TID_W-1:0]          wb_slot_tid,
    input logic                      issue_hazard,
    input logic [N_THREADS*PC_W-1:0] pc_flat
);

    function automatic logic [TID_W-1:0] ring_succ(input logic [TID_W-1:0] t);
        return (t == TID_W'(N_THREADS - 1)) ? '0 : t + TID_W'(1);
    endfunction

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (fetch_tid == '0 && !wb_slot_valid && pc_flat[PC_W-1:0] == RST_BASE));

    assert_ring_step_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (fetch_tid == ring_succ($past(fetch_tid))));

    assert_tail_tag_R4: assert property (@(posedge clk) disable iff (rst)
        wb_slot_valid |-> (wb_slot_tid == ring_succ(fetch_tid)));

    assert_no_hazard_R8: assert property (@(posedge clk) disable iff (rst)
        !issue_hazard);

    for (genvar t = 0; t < N_THREADS; t++) begin : g_pc
        assert_pc_write_R5: assert property (@(posedge clk) disable iff (rst)
            (wb_valid && wb_tid == TID_W'(t)) |=> (pc_flat[t*PC_W +: PC_W] == $past(wb_pc)));

        assert_pc_hold_R9: assert property (@(posedge clk) disable iff (rst)
            !(wb_valid && wb_tid == TID_W'(t)) |=> $stable(pc_flat[t*PC_W +: PC_W]));
    end

endmodule

bind barrel_sequencer barrel_sequencer_chk #(
    .N_THREADS (N_THREADS),
    .PC_W      (PC_W),
    .TID_W     (TID_W),
    .RST_BASE  (RST_BASE)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .wb_valid      (wb_valid),
    .wb_tid        (wb_tid),
    .wb_pc         (wb_pc),
    .fetch_tid     (fetch_tid),
    .wb_slot_valid (wb_slot_valid),
    .wb_slot_tid   (wb_slot_tid),
    .issue_hazard  (issue_hazard),
    .pc_flat       (pc_flat)
);

// File: tb/tb_barrel_sequencer.sv
module tb_barrel_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int NT         = 7;
    localparam int TW         = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NT-1:0] thread_en = '1;
    logic          wb_valid = 1'b0;
    logic [TW-1:0] wb_tid = '0;
    logic [31:0]   wb_pc = '0;
    logic          fetch_valid;
    logic [TW-1:0] fetch_tid;
    logic [31:0]   fetch_pc;
    logic          wb_slot_valid;
    logic [TW-1:0] wb_slot_tid;
    logic          issue_hazard;

    int total = 0;
    int bad = 0;
    bit done = 0;

    int          exp_tid;
    logic [31:0] pc_m [NT];
    bit          last_iv [NT];

    always #(CLK_PERIOD/2) clk = ~clk;

    barrel_sequencer dut (
        .clk           (clk),
        .rst           (rst),
        .thread_en     (thread_en),
        .wb_valid      (wb_valid),
        .wb_tid        (wb_tid),
        .wb_pc         (wb_pc),
        .fetch_valid   (fetch_valid),
        .fetch_tid     (fetch_tid),
        .fetch_pc      (fetch_pc),
        .wb_slot_valid (wb_slot_valid),
        .wb_slot_tid   (wb_slot_tid),
        .issue_hazard  (issue_hazard)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Called at a falling edge: check this cycle, drive writeback, advance to the next falling edge.
    // mode 0: no writeback, 1: writeback from the tail slot with pc+4, 2: explicit writeback.
    task automatic step(input int mode, input int wtid, input logic [31:0] wpc);
        int  nxt;
        bit  sv;
        nxt = (exp_tid + 1) % NT;
        sv  = last_iv[nxt];
        chk(fetch_tid == TW'(exp_tid), "R2 ring order", 32'(fetch_tid), 32'(exp_tid));
        chk(fetch_valid == thread_en[exp_tid], "R7 issue valid", 32'(fetch_valid), 32'(thread_en[exp_tid]));
        chk(fetch_pc == pc_m[exp_tid], "R3 fetch pc", fetch_pc, pc_m[exp_tid]);
        chk(wb_slot_valid == sv, "R4 tail valid", 32'(wb_slot_valid), 32'(sv));
        if (sv) chk(wb_slot_tid == TW'(nxt), "R4 tail tid", 32'(wb_slot_tid), 32'(nxt));
        chk(issue_hazard == 1'b0, "R8 hazard", 32'(issue_hazard), 32'd0);
        last_iv[exp_tid] = thread_en[exp_tid];
        wb_valid = 1'b0;
        if (mode == 1 && sv) begin
            wb_valid = 1'b1; wb_tid = TW'(nxt); wb_pc = pc_m[nxt] + 32'd4;
            pc_m[nxt] = pc_m[nxt] + 32'd4;
        end else if (mode == 2) begin
            wb_valid = 1'b1; wb_tid = TW'(wtid); wb_pc = wpc;
            if (wtid < NT) pc_m[wtid] = wpc;
        end
        exp_tid = nxt;
        @(negedge clk);
        wb_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        exp_tid = 0;
        for (int t = 0; t < NT; t++) begin
            pc_m[t] = 32'h1000 + 32'(t) * 32'h100;
            last_iv[t] = 1'b0;
        end
        chk(fetch_tid == '0, "R1 reset tid", 32'(fetch_tid), 32'd0);
        chk(fetch_pc == 32'h1000, "R1 reset pc", fetch_pc, 32'h1000);
        chk(wb_slot_valid == 1'b0, "R1 pipe empty", 32'(wb_slot_valid), 32'd0);
    endtask

    task automatic t_rotate_idle();
        for (int i = 0; i < 2 * NT + 2; i++) step(0, 0, '0);
    endtask

    task automatic t_wb_loop();
        for (int i = 0; i < 3 * NT; i++) step(1, 0, '0);
    endtask

    task automatic t_same_cycle();
        int          tgt;
        logic [31:0] old;
        tgt = exp_tid;
        old = pc_m[tgt];
        wb_valid = 1'b1; wb_tid = TW'(tgt); wb_pc = 32'hABCD_0000;
        #1;
        chk(fetch_pc == old, "R6 same-cycle fetch keeps old", fetch_pc, old);
        wb_valid = 1'b0;
        step(2, tgt, 32'hABCD_0000);
        for (int i = 0; i < NT - 1; i++) step(0, 0, '0);
        chk(fetch_tid == TW'(tgt), "R6 return to thread", 32'(fetch_tid), 32'(tgt));
        chk(fetch_pc == 32'hABCD_0000, "R6 new pc visible", fetch_pc, 32'hABCD_0000);
        step(0, 0, '0);
    endtask

    task automatic t_bad_tid();
        step(2, NT, 32'hDEAD_BEEF);
        for (int i = 0; i < NT + 1; i++) step(0, 0, '0);
        for (int t = 0; t < NT; t++)
            chk(pc_m[t] != 32'hDEAD_BEEF, "R9 model untouched", pc_m[t], 32'h0);
    endtask

    task automatic t_mask();
        thread_en = 7'b111_0111;
        for (int i = 0; i < 2 * NT; i++) step(1, 0, '0);
        thread_en = 7'b010_1010;
        for (int i = 0; i < 2 * NT; i++) step(1, 0, '0);
        thread_en = '1;
        for (int i = 0; i < 2 * NT; i++) step(1, 0, '0);
    endtask

    initial begin
        t_reset();
        t_rotate_idle();
        t_wb_loop();
        t_same_cycle();
        t_bad_tid();
        t_mask();
        t_reset();
        t_rotate_idle();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule